// File: doc/BRIEF.md
# Context-Saving Call and Interrupt Return Stack

This block is the hardware return stack of a small two-stage-pipelined 8-bit controller core. Each entry keeps more than a return address. It also keeps the accumulator, the status flags and the instruction that had already been prefetched when the call or interrupt happened. A return can then hand all of that straight back to the pipeline. The core needs no context-saving code in a handler, and it needs no refill bubble after a return. A second store, the vector word register, holds the first instruction of the interrupt handler, fetched in advance. Interrupt entry therefore needs no fetch cycle.

The core pushes through a plain strobe. Returns are requested on a valid/ready pop port. The restored context leaves on a registered valid/ready restore port. The restore register holds its content while the consumer stalls. A new pop is accepted only when that register is empty or is being drained in the same cycle. An input bit selects fast mode. An entry pushed with the bit clear gives back only its address on return, as a plain address stack would. The vector word is loaded through a request/response fetch port. The request side obeys ready. The response side has no back-pressure, and only one request is ever outstanding.

Top module: `ctx_return_stack`

## Requirements
- R1: With fast_en high at push time, a pop returns the pushed pc, acc, stat and insn in last-in first-out order, with rp_full_ctx high, and level counts pushes minus pops.
- R2: A pop accepted at a clock edge makes rp_valid high in the next cycle. pop_ready equals (not rp_valid) or rp_ready. While rp_valid is high and rp_ready is low, every restore output holds steady and no further pop is taken.
- R3: An entry pushed with fast_en low returns its pc with rp_full_ctx low and with rp_acc, rp_stat and rp_insn all zero.
- R4: The stack holds 16 entries. A 17th push sets the sticky ovf_flag, keeps level at 16 and overwrites the oldest entry. The following 16 pops return the newest 16 entries.
- R5: A pop on an empty stack still produces a restore beat. That beat carries all-zero fields, sets the sticky unf_flag and leaves level at 0.
- R6: When push_req and an accepted pop fall in the same cycle, the pop is performed, the push is dropped and the sticky err_flag is set.
- R7: If irq_req is high in cycle c, the context on the push ports is pushed at the end of cycle c+1. vec_go is then high for exactly cycle c+2, whatever instruction or stream traffic is in progress.
- R8: During vec_go, vec_hit is high only when fast_en was high in cycle c+1 and the vector word was loaded. vec_insn then carries the fetched word.
- R9: After reset, after a vec_refresh pulse and after each vec_go, the block raises fetch_req_valid with fetch_addr equal to the vector address (4). It keeps the request raised until fetch_req_ready is high, then captures fetch_rsp_data on the next fetch_rsp_valid. Until that capture, vec_hit stays low.
- R10: ovf_flag, unf_flag and err_flag clear only on reset. After reset the level is 0, rp_valid is 0 and vec_go is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_en | input | 1 | Fast context mode enable |
| push_req | input | 1 | Call push strobe |
| push_pc | input | 13 | Return address to save |
| push_acc | input | 8 | Accumulator to save |
| push_stat | input | 8 | Status flags to save |
| push_insn | input | 14 | Prefetched instruction to save |
| pop_valid | input | 1 | Return request |
| pop_ready | output | 1 | Return request accepted |
| rp_valid | output | 1 | Restore beat valid |
| rp_ready | input | 1 | Pipeline takes the restore beat |
| rp_pc | output | 13 | Restored address |
| rp_acc | output | 8 | Restored accumulator |
| rp_stat | output | 8 | Restored status |
| rp_insn | output | 14 | Restored prefetched instruction |
| rp_full_ctx | output | 1 | Beat carries full context (no refill) |
| irq_req | input | 1 | Interrupt request |
| vec_go | output | 1 | Handler starts this cycle |
| vec_hit | output | 1 | vec_insn usable without fetch |
| vec_insn | output | 14 | Preloaded handler instruction |
| vec_refresh | input | 1 | Vector contents changed; reload |
| fetch_req_valid | output | 1 | Fetch request valid |
| fetch_req_ready | input | 1 | Fetch request accepted |
| fetch_addr | output | 13 | Fetch address |
| fetch_rsp_valid | input | 1 | Fetch data valid |
| fetch_rsp_data | input | 14 | Fetched word |
| level | output | 5 | Entries held |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |
| err_flag | output | 1 | Sticky push/pop clash |

## Verification
The stack is driven with nested pushes in fast mode, with a push in compatibility mode, with a run that goes one entry past full and then drains the stack to underflow, and with a push that collides with a pop. Together these separate correct ordering, masking of the context fields and pointer wrap from the sticky error paths. The restore port is stalled across several cycles to show that the beat holds and that no pop slips through. Interrupt entries are taken in fast and in compatibility mode, with a changed vector word and a stalled fetch port. These show the fixed two-cycle timing, the hit rule and the reload path.

// File: rtl/ctxstk_pkg.sv
package ctxstk_pkg;
  parameter int PC_W = 13;
  parameter int D_W  = 8;
  parameter int I_W  = 14;

  typedef struct packed {
    logic            fast;
    logic [PC_W-1:0] pc;
    logic [D_W-1:0]  acc;
    logic [D_W-1:0]  stat;
    logic [I_W-1:0]  insn;
  } ctx_t;

  typedef enum logic [1:0] {VS_HOLD, VS_REQ, VS_WAIT} vstate_t;
endpackage

// File: rtl/ctxstk_store.sv
module ctxstk_store import ctxstk_pkg::*; #(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         do_push,
  input  logic                         do_pop,
  input  ctx_t                         wdata,
  output ctx_t                         rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         ovf,
  output logic                         unf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH-1);

  ctx_t           mem [DEPTH];
  logic [PW-1:0]  wr_ptr;
  logic [PW-1:0]  rd_idx;

  assign rd_idx = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;
  assign rdata  = (level == '0) ? '0 : mem[rd_idx];

  always_ff @(posedge clk) begin
    if (do_push && !do_pop) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      level  <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else if (do_pop) begin
      if (level == '0) begin
        unf <= 1'b1;
      end else begin
        wr_ptr <= rd_idx;
        level  <= level - 1'b1;
      end
    end else if (do_push) begin
      wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (level == FULL) ovf <= 1'b1;
      else               level <= level + 1'b1;
    end
  end

  p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL);
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  p_unf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> unf);
  p_full_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    do_push && !do_pop && level == FULL |=> ovf && level == FULL);
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop && level == '0 |=> unf && level == '0);
  p_pop_shrinks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop && level != '0 |=> level == LW'($past(level) - 1'b1));
endmodule

// File: rtl/ctxstk_vec.sv
module ctxstk_vec import ctxstk_pkg::*; #(
  parameter int VEC_ADDR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reload,
  output logic            fetch_req_valid,
  input  logic            fetch_req_ready,
  output logic [PC_W-1:0] fetch_addr,
  input  logic            fetch_rsp_valid,
  input  logic [I_W-1:0]  fetch_rsp_data,
  output logic [I_W-1:0]  vec_insn,
  output logic            vec_loaded
);
  vstate_t state;

  assign fetch_req_valid = (state == VS_REQ);
  assign fetch_addr      = PC_W'(VEC_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= VS_REQ;
      vec_insn   <= '0;
      vec_loaded <= 1'b0;
    end else if (reload) begin
      state      <= VS_REQ;
      vec_loaded <= 1'b0;
    end else begin
      case (state)
        VS_REQ:  if (fetch_req_ready) state <= VS_WAIT;
        VS_WAIT: if (fetch_rsp_valid) begin
          state      <= VS_HOLD;
          vec_insn   <= fetch_rsp_data;
          vec_loaded <= 1'b1;
        end
        default: state <= VS_HOLD;
      endcase
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_valid && !fetch_req_ready && !reload |=> fetch_req_valid);
  p_reload_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !vec_loaded && fetch_req_valid);
endmodule

// File: rtl/ctxstk_irq.sv
module ctxstk_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic fast_en,
  input  logic vec_loaded,
  output logic irq_push,
  output logic vec_go,
  output logic vec_hit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_push <= 1'b0;
      vec_go   <= 1'b0;
      vec_hit  <= 1'b0;
    end else begin
      irq_push <= irq_req && !irq_push;
      vec_go   <= irq_push;
      vec_hit  <= irq_push && fast_en && vec_loaded;
    end
  end

  p_fixed_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_push |=> ##1 vec_go);
  p_go_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_go |=> !vec_go);
  p_hit_in_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_hit |-> vec_go);
endmodule

// File: rtl/ctx_return_stack.sv
module ctx_return_stack import ctxstk_pkg::*; #(
  parameter int DEPTH    = 16,
  parameter int VEC_ADDR = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fast_en,
  input  logic                       push_req,
  input  logic [PC_W-1:0]            push_pc,
  input  logic [D_W-1:0]             push_acc,
  input  logic [D_W-1:0]             push_stat,
  input  logic [I_W-1:0]             push_insn,
  input  logic                       pop_valid,
  output logic                       pop_ready,
  output logic                       rp_valid,
  input  logic                       rp_ready,
  output logic [PC_W-1:0]            rp_pc,
  output logic [D_W-1:0]             rp_acc,
  output logic [D_W-1:0]             rp_stat,
  output logic [I_W-1:0]             rp_insn,
  output logic                       rp_full_ctx,
  input  logic                       irq_req,
  output logic                       vec_go,
  output logic                       vec_hit,
  output logic [I_W-1:0]             vec_insn,
  input  logic                       vec_refresh,
  output logic                       fetch_req_valid,
  input  logic                       fetch_req_ready,
  output logic [PC_W-1:0]            fetch_addr,
  input  logic                       fetch_rsp_valid,
  input  logic [I_W-1:0]             fetch_rsp_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       ovf_flag,
  output logic                       unf_flag,
  output logic                       err_flag
);
  logic irq_push, vec_loaded, pop_go, push_any, do_push;
  ctx_t wdata, rdata;

  assign pop_ready = !rp_valid || rp_ready;
  assign pop_go    = pop_valid && pop_ready;
  assign push_any  = push_req || irq_push;
  assign do_push   = push_any && !pop_go;

  assign wdata.fast = fast_en;
  assign wdata.pc   = push_pc;
  assign wdata.acc  = push_acc;
  assign wdata.stat = push_stat;
  assign wdata.insn = push_insn;

  ctxstk_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .do_push(do_push), .do_pop(pop_go),
    .wdata(wdata), .rdata(rdata), .level(level), .ovf(ovf_flag), .unf(unf_flag)
  );

  ctxstk_irq u_irq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .fast_en(fast_en),
    .vec_loaded(vec_loaded), .irq_push(irq_push), .vec_go(vec_go), .vec_hit(vec_hit)
  );

  ctxstk_vec #(.VEC_ADDR(VEC_ADDR)) u_vec (
    .clk(clk), .rst_n(rst_n), .reload(vec_refresh || vec_go),
    .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
    .fetch_addr(fetch_addr), .fetch_rsp_valid(fetch_rsp_valid),
    .fetch_rsp_data(fetch_rsp_data), .vec_insn(vec_insn), .vec_loaded(vec_loaded)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp_valid    <= 1'b0;
      rp_pc       <= '0;
      rp_acc      <= '0;
      rp_stat     <= '0;
      rp_insn     <= '0;
      rp_full_ctx <= 1'b0;
      err_flag    <= 1'b0;
    end else begin
      if (push_any && pop_go) err_flag <= 1'b1;
      if (pop_go) begin
        rp_valid    <= 1'b1;
        rp_pc       <= rdata.pc;
        rp_full_ctx <= rdata.fast;
        rp_acc      <= rdata.fast ? rdata.acc  : '0;
        rp_stat     <= rdata.fast ? rdata.stat : '0;
        rp_insn     <= rdata.fast ? rdata.insn : '0;
      end else if (rp_ready) begin
        rp_valid <= 1'b0;
      end
    end
  end

  p_hold_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rp_valid && !rp_ready |=> rp_valid && $stable(rp_pc) && $stable(rp_insn)
                              && $stable(rp_acc) && $stable(rp_full_ctx));
  p_clash_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && pop_valid && pop_ready |=> err_flag);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  p_compat_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rp_valid && !rp_full_ctx |-> rp_acc == '0 && rp_stat == '0 && rp_insn == '0);
endmodule

// File: tb/sim_ctx_return_stack.sv
module sim_ctx_return_stack;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_en = 1'b0, push_req = 1'b0, pop_valid = 1'b0, rp_ready = 1'b1;
  logic [12:0] push_pc = '0;
  logic [7:0]  push_acc = '0, push_stat = '0;
  logic [13:0] push_insn = '0;
  logic irq_req = 1'b0, vec_refresh = 1'b0, req_rdy = 1'b1;
  logic fetch_req_valid, fetch_rsp_valid = 1'b0;
  logic [13:0] fetch_rsp_data = '0, vec_word = 14'h2AB;
  logic [12:0] fetch_addr, rp_pc;
  logic pop_ready, rp_valid, rp_full_ctx, vec_go, vec_hit;
  logic [7:0] rp_acc, rp_stat;
  logic [13:0] rp_insn, vec_insn;
  logic [4:0] level;
  logic ovf_flag, unf_flag, err_flag;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_return_stack u0 (
    .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .push_req(push_req),
    .push_pc(push_pc), .push_acc(push_acc), .push_stat(push_stat), .push_insn(push_insn),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .rp_valid(rp_valid), .rp_ready(rp_ready),
    .rp_pc(rp_pc), .rp_acc(rp_acc), .rp_stat(rp_stat), .rp_insn(rp_insn),
    .rp_full_ctx(rp_full_ctx), .irq_req(irq_req), .vec_go(vec_go), .vec_hit(vec_hit),
    .vec_insn(vec_insn), .vec_refresh(vec_refresh), .fetch_req_valid(fetch_req_valid),
    .fetch_req_ready(req_rdy), .fetch_addr(fetch_addr), .fetch_rsp_valid(fetch_rsp_valid),
    .fetch_rsp_data(fetch_rsp_data), .level(level), .ovf_flag(ovf_flag),
    .unf_flag(unf_flag), .err_flag(err_flag)
  );

  // program memory model: one-cycle response to an accepted request
  always @(posedge clk) begin
    fetch_rsp_valid <= fetch_req_valid && req_rdy;
    fetch_rsp_data  <= vec_word;
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; push_req = 0; pop_valid = 0; irq_req = 0; vec_refresh = 0;
    rp_ready = 1; req_rdy = 1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input logic [12:0] pc, input logic [7:0] a, input logic [7:0] s,
                      input logic [13:0] i);
    @(negedge clk);
    push_req = 1; push_pc = pc; push_acc = a; push_stat = s; push_insn = i;
    @(negedge clk);
    push_req = 0;
  endtask

  task automatic pop();
    @(negedge clk);
    pop_valid = 1;
    tick();
    @(negedge clk);
    pop_valid = 0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R10 level after reset", level, 0);
    chk("R10 flags after reset", {ovf_flag, unf_flag, err_flag}, 0);
    chk("R10 rp_valid/vec_go after reset", {rp_valid, vec_go}, 0);
    chk("R9 fetch request after reset", {fetch_req_valid, fetch_addr}, {1'b1, 13'd4});
  endtask

  task automatic t_lifo_fast();
    do_reset(); fast_en = 1;
    for (int k = 1; k <= 3; k++) push(13'(k * 16), 8'(k), 8'(k + 8), 14'(k * 100));
    chk("R1 level after 3 pushes", level, 3);
    for (int k = 3; k >= 1; k--) begin
      @(negedge clk); pop_valid = 1; tick();
      chk("R1 pc order", rp_pc, k * 16);
      chk("R1 acc/stat", {rp_acc, rp_stat}, {8'(k), 8'(k + 8)});
      chk("R1 insn and full flag", {rp_full_ctx, rp_insn}, {1'b1, 14'(k * 100)});
      @(negedge clk); pop_valid = 0;
    end
    chk("R1 level after pops", level, 0);
  endtask

  task automatic t_compat();
    do_reset(); fast_en = 0;
    push(13'h123, 8'h55, 8'h0F, 14'h3A5);
    @(negedge clk); pop_valid = 1; tick();
    chk("R3 pc returned", rp_pc, 13'h123);
    chk("R3 context masked", {rp_full_ctx, rp_acc, rp_stat, rp_insn}, 0);
    @(negedge clk); pop_valid = 0;
  endtask

  task automatic t_backpressure();
    do_reset(); fast_en = 1;
    push(13'h010, 8'h1, 8'h1, 14'h1);
    push(13'h020, 8'h2, 8'h2, 14'h2);
    @(negedge clk); rp_ready = 0; pop_valid = 1;
    tick();
    chk("R2 beat one cycle after pop", {rp_valid, rp_pc}, {1'b1, 13'h020});
    chk("R2 pop_ready low when stalled", pop_ready, 0);
    tick(); tick();
    chk("R2 beat held", {rp_valid, rp_pc, rp_insn}, {1'b1, 13'h020, 14'h2});
    chk("R2 no pop while stalled", level, 1);
    @(negedge clk); rp_ready = 1;
    tick();
    chk("R2 next beat after drain", {rp_valid, rp_pc, level}, {1'b1, 13'h010, 5'd0});
    @(negedge clk); pop_valid = 0;
    tick();
    chk("R2 valid drops when consumed", rp_valid, 0);
  endtask

  task automatic t_overflow();
    do_reset(); fast_en = 1;
    for (int k = 0; k < 16; k++) push(13'(k), 8'(k), 8'h0, 14'(k));
    chk("R4 full without overflow", {ovf_flag, level}, {1'b0, 5'd16});
    push(13'd16, 8'd16, 8'h0, 14'd16);
    chk("R4 overflow sticky, level 16", {ovf_flag, level}, {1'b1, 5'd16});
    for (int k = 16; k >= 1; k--) begin
      @(negedge clk); pop_valid = 1; tick();
      chk("R4 newest sixteen returned", rp_pc, k);
      @(negedge clk); pop_valid = 0;
    end
    chk("R4 drained", {level, unf_flag}, {5'd0, 1'b0});
    @(negedge clk); pop_valid = 1; tick();
    chk("R5 underflow after drain", {rp_valid, rp_pc, unf_flag}, {1'b1, 13'd0, 1'b1});
    @(negedge clk); pop_valid = 0;
    chk("R10 overflow still set", ovf_flag, 1);
  endtask

  task automatic t_underflow();
    do_reset(); fast_en = 1;
    @(negedge clk); pop_valid = 1; tick();
    chk("R5 zero beat on empty", {rp_valid, rp_pc, rp_acc, rp_stat, rp_insn},
        {1'b1, 43'd0});
    chk("R5 unf set, level 0", {unf_flag, level}, {1'b1, 5'd0});
    @(negedge clk); pop_valid = 0;
  endtask

  task automatic t_conflict();
    do_reset(); fast_en = 1;
    push(13'h0AA, 8'h1, 8'h2, 14'h3);
    @(negedge clk);
    push_req = 1; push_pc = 13'h0BB; pop_valid = 1;
    tick();
    chk("R6 pop wins", {rp_pc, level}, {13'h0AA, 5'd0});
    chk("R6 err flag", err_flag, 1);
    @(negedge clk); push_req = 0; pop_valid = 0;
    pop();
    chk("R6 dropped push left nothing", unf_flag, 1);
  endtask

  task automatic t_irq(input logic fast, input logic [13:0] word);
    fast_en = fast;
    repeat (5) @(negedge clk);
    push_pc = 13'h0777; push_acc = 8'hC3; push_stat = 8'h5A; push_insn = 14'h1234;
    irq_req = 1;
    tick();
    chk("R7 no go one cycle after request", vec_go, 0);
    @(negedge clk); irq_req = 0;
    tick();
    chk("R7 go two cycles after request", vec_go, 1);
    chk("R8 hit follows mode", vec_hit, fast);
    if (fast) chk("R8 vector word", vec_insn, word);
    chk("R7 context pushed", level, 1);
    tick();
    chk("R7 go is one cycle", vec_go, 0);
    @(negedge clk); pop_valid = 1; tick();
    chk("R7 irq context restored", {rp_pc, rp_full_ctx}, {13'h0777, fast});
    if (fast) chk("R1 irq acc/stat/insn", {rp_acc, rp_stat, rp_insn}, {8'hC3, 8'h5A, 14'h1234});
    @(negedge clk); pop_valid = 0;
  endtask

  task automatic t_vec_reload();
    do_reset(); fast_en = 1;
    repeat (5) @(negedge clk);
    vec_word = 14'h155; req_rdy = 0; vec_refresh = 1;
    @(negedge clk); vec_refresh = 0;
    repeat (3) @(negedge clk);
    chk("R9 request held while not ready", {fetch_req_valid, fetch_addr}, {1'b1, 13'd4});
    irq_req = 1; tick(); @(negedge clk); irq_req = 0; tick();
    chk("R9 no hit before reload done", {vec_go, vec_hit}, {1'b1, 1'b0});
    @(negedge clk); req_rdy = 1;
    pop();
    t_irq(1'b1, 14'h155);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_lifo_fast();
    t_compat();
    t_backpressure();
    t_overflow();
    t_underflow();
    t_conflict();
    do_reset(); t_irq(1'b1, 14'h2AB);
    do_reset(); t_irq(1'b0, 14'h2AB);
    t_vec_reload();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule